// File: doc/BRIEF.md
# Page-Bounded Line Stream Prefetcher

This block watches the cache-line requests that the first-level caches send downstream. It keeps a small table of streams, one per 4 KB page. Each stream learns whether accesses in that page walk upward or downward one 64-byte line at a time. Once a stream has shown a steady step in one direction, each new access to it yields a prefetch request a fixed distance ahead, in the direction of travel.

A prefetch target is never allowed to leave the page of the access that produced it. A stream therefore stops at the page edge. Prefetching resumes in the neighbouring page only after demand traffic arrives there, opens a new stream and trains it again.

Requests enter on a plain strobe with address, source and miss flag. The strobe has no back-pressure, so every strobed request is consumed in its cycle. Prefetches leave on a one-deep valid/ready port. An offered request stays frozen while `pf_ready` is low. Any new candidate that arrives while the slot is blocked is discarded and is not queued.

Top module: `line_stream_pf`

## Requirements
- R1: Streams are tracked both upward and downward. The line index is `req_addr[11:6]`, the page is `req_addr[ADDR_W-1:12]` and `req_addr[5:0]` is ignored. Prefetches follow the learned direction of the stream.
- R2: A stream becomes confirmed after two successive same-page accesses that each step by exactly one line in the same direction. From then on, each access to the stream offers a prefetch of the line DIST (2) lines ahead of it. The offer appears on `pf_valid`/`pf_addr` after the clock edge that accepts the request, and `pf_addr[5:0]` is zero. A step in the opposite direction clears the confidence and adopts the new direction, so two further steps are needed before the next prefetch.
- R3: A candidate line that falls outside the page of the triggering access (index above 63 or below 0) is never offered.
- R4: A stream never continues into an adjacent page. A new page produces prefetches only after requests in that page have allocated a stream and confirmed it there.
- R5: Source codes on `req_src` are 0 for load, 1 for store, 2 for instruction fetch and 3 for prefetcher-originated. Requests with any of these sources advance an existing stream.
- R6: A request with `req_miss` low that matches no stream allocates nothing.
- R7: A request with source 3 never allocates a stream, even when it misses.
- R8: The table has ENTRIES (8) streams, each for a distinct page. An allocating miss fills a free entry if one exists, and otherwise replaces the least recently used stream.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_addr` holds steady. A candidate that arrives while the slot is blocked in this way is discarded.
- R10: A candidate equal to the most recently offered line is dropped. A repeated access to a stream's current line leaves its direction and confidence unchanged.
- R11: Reset empties the table and deasserts `pf_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle, no back-pressure |
| req_addr | input | ADDR_W | Physical byte address of the request |
| req_src | input | 2 | Request source code (see R5) |
| req_miss | input | 1 | High when the request missed in the first-level cache |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |

## Verification
The bench walks streams that end at the top and bottom edges of a page. A design that fails to clamp there would offer a line belonging to the wrong page. It steps into the next page expecting silence until that page has been retrained; a design that carries a stream across the edge would prefetch at once. It also reverses a confirmed stream, which a design that keeps its confidence on reversal would answer with an early prefetch. Other cases cover hits and prefetcher-sourced misses that must not allocate, a blocked output slot that must neither move nor queue the candidate, a repeated line that must not be offered twice, and a ninth page that must evict exactly the least recently touched stream.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int LINE_OFF_W = 6;
  localparam int PAGE_OFF_W = 12;
  localparam int IDX_W      = PAGE_OFF_W - LINE_OFF_W;
  localparam int CONF_W     = 2;
  localparam logic [CONF_W-1:0] CONF_MAX     = 2'd3;
  localparam logic [CONF_W-1:0] CONF_CONFIRM = 2'd2;

  typedef enum logic [1:0] {
    SRC_LOAD   = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_IFETCH = 2'd2,
    SRC_PFETCH = 2'd3
  } src_e;
endpackage

// File: rtl/lsp_lru.sv
module lsp_lru #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)           age[i] <= '0;
        else if (age[i] < age[touch_idx])  age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age[g] == IW'(N - 1));
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++) if (oldest[i]) victim = IW'(i);
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R8
endmodule

// File: rtl/lsp_train.sv
module lsp_train
  import lsp_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 20,
  parameter int DIST    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [1:0]        req_src,
  input  logic              req_miss,
  output logic              cand_valid,
  output logic [IDX_W-1:0]  cand_idx
);
  localparam int EW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_v;
  logic [ENTRIES-1:0] ent_dir;   // 0 = upward, 1 = downward
  logic [PAGE_W-1:0]  ent_page [ENTRIES];
  logic [IDX_W-1:0]   ent_line [ENTRIES];
  logic [CONF_W-1:0]  ent_conf [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, have_free, alloc_en;
  logic [EW-1:0]      hit_idx, free_idx, alloc_idx, victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_page[g] == req_page);
  end

  always_comb begin
    hit_idx   = '0;
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = EW'(i);
      if (!ent_v[i]) begin
        free_idx  = EW'(i);
        have_free = 1'b1;
      end
    end
  end

  assign hit_any   = |hit_vec;
  assign alloc_idx = have_free ? free_idx : victim;
  assign alloc_en  = req_valid && !hit_any && req_miss && (src_e'(req_src) != SRC_PFETCH);

  // Training of the matched stream
  logic [IDX_W:0]    cur_w, req_w, tgt_w;
  logic              step_up, step_dn, step_dir, nxt_dir;
  logic [CONF_W-1:0] cur_conf, nxt_conf;

  assign cur_w    = {1'b0, ent_line[hit_idx]};
  assign req_w    = {1'b0, req_idx};
  assign cur_conf = ent_conf[hit_idx];
  assign step_up  = (req_w == cur_w + 1'b1);
  assign step_dn  = (req_w + 1'b1 == cur_w);
  assign step_dir = step_dn;

  always_comb begin
    nxt_dir  = ent_dir[hit_idx];
    nxt_conf = cur_conf;
    if (req_w == cur_w) begin
      nxt_conf = cur_conf;
    end else if (step_up || step_dn) begin
      nxt_dir = step_dir;
      if (cur_conf == '0 || step_dir == ent_dir[hit_idx])
        nxt_conf = (cur_conf == CONF_MAX) ? CONF_MAX : cur_conf + 1'b1;
      else
        nxt_conf = '0;
    end else begin
      nxt_conf = '0;
    end
  end

  assign tgt_w      = nxt_dir ? (req_w - (IDX_W+1)'(DIST)) : (req_w + (IDX_W+1)'(DIST));
  assign cand_valid = req_valid && hit_any && (nxt_conf >= CONF_CONFIRM) && !tgt_w[IDX_W];
  assign cand_idx   = tgt_w[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_dir <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_page[i] <= '0;
        ent_line[i] <= '0;
        ent_conf[i] <= '0;
      end
    end else if (req_valid && hit_any) begin
      ent_line[hit_idx] <= req_idx;
      ent_dir[hit_idx]  <= nxt_dir;
      ent_conf[hit_idx] <= nxt_conf;
    end else if (alloc_en) begin
      ent_v[alloc_idx]    <= 1'b1;
      ent_page[alloc_idx] <= req_page;
      ent_line[alloc_idx] <= req_idx;
      ent_dir[alloc_idx]  <= 1'b0;
      ent_conf[alloc_idx] <= '0;
    end
  end

  lsp_lru #(.N(ENTRIES), .IW(EW)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch    (req_valid && (hit_any || alloc_en)),
    .touch_idx(hit_any ? hit_idx : alloc_idx),
    .victim   (victim)
  );

  AST_PAGE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
  AST_PF_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src == 2'd3 && !hit_any) |=> $stable(ent_v)); // R7
  AST_HIT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_miss && !hit_any) |=> $stable(ent_v)); // R6
endmodule

// File: rtl/lsp_issue.sv
module lsp_issue #(
  parameter int LW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_valid,
  input  logic [LW-1:0] cand_line,
  input  logic          pf_ready,
  output logic          pf_valid,
  output logic [LW-1:0] pf_line
);
  logic [LW-1:0] last_line;
  logic          last_v, dup, load;

  assign dup  = last_v && (last_line == cand_line);
  assign load = cand_valid && !dup && (!pf_valid || pf_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid  <= 1'b0;
      pf_line   <= '0;
      last_line <= '0;
      last_v    <= 1'b0;
    end else if (load) begin
      pf_valid  <= 1'b1;
      pf_line   <= cand_line;
      last_line <= cand_line;
      last_v    <= 1'b1;
    end else if (pf_ready) begin
      pf_valid  <= 1'b0;
    end
  end

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line))); // R9
endmodule

// File: rtl/line_stream_pf.sv
module line_stream_pf
  import lsp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int DIST    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_src,
  input  logic              req_miss,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  localparam int PAGE_W = ADDR_W - PAGE_OFF_W;
  localparam int LW     = ADDR_W - LINE_OFF_W;

  logic [PAGE_W-1:0] req_page;
  logic [IDX_W-1:0]  req_idx, cand_idx;
  logic              cand_valid;
  logic [LW-1:0]     pf_line;
  logic              unused_off;

  assign req_page   = req_addr[ADDR_W-1:PAGE_OFF_W];
  assign req_idx    = req_addr[PAGE_OFF_W-1:LINE_OFF_W];
  assign unused_off = ^req_addr[LINE_OFF_W-1:0];

  lsp_train #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .DIST(DIST)) u_train (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_page  (req_page),
    .req_idx   (req_idx),
    .req_src   (req_src),
    .req_miss  (req_miss),
    .cand_valid(cand_valid),
    .cand_idx  (cand_idx)
  );

  lsp_issue #(.LW(LW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_valid(cand_valid),
    .cand_line ({req_page, cand_idx}),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_line   (pf_line)
  );

  assign pf_addr = {pf_line, {LINE_OFF_W{1'b0}}};

  AST_PF_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> (pf_addr[ADDR_W-1:PAGE_OFF_W] == $past(req_page))); // R3
  AST_PF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[LINE_OFF_W-1:0] == '0)); // R2
endmodule

// File: tb/line_stream_pf_tb.sv
module line_stream_pf_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;

  localparam logic [19:0] P1 = 20'h12345, P2 = 20'h0ABCD, P3 = 20'h00F00, P4 = 20'h00F01;
  localparam logic [19:0] P5 = 20'h22222, P6 = 20'h33333, P7 = 20'h44444, P8 = 20'h55555;
  localparam logic [19:0] P9 = 20'h66661, P10 = 20'h66662, P11 = 20'h66663;

  // {src[35:34], miss[33], page[32:13], idx[12:7], exp_valid[6], exp_idx[5:0]}
  function automatic logic [35:0] mk(logic [1:0] s, logic m, logic [19:0] p, int i, logic ev, int ei);
    return {s, m, p, 6'(i), ev, 6'(ei)};
  endfunction

  localparam int NV = 32;
  localparam logic [35:0] VEC [NV] = '{
    mk(0,1,P1,10,0,0),  mk(0,0,P1,11,0,0),  mk(0,0,P1,12,1,14), mk(1,0,P1,13,1,15),
    mk(2,0,P1,14,1,16), mk(3,0,P1,15,1,17),
    mk(0,1,P2,40,0,0),  mk(0,0,P2,39,0,0),  mk(0,0,P2,38,1,36), mk(1,0,P2,37,1,35),
    mk(0,0,P2,38,0,0),  mk(0,0,P2,39,0,0),  mk(0,0,P2,40,1,42),
    mk(0,1,P3,60,0,0),  mk(0,0,P3,61,0,0),  mk(0,0,P3,62,0,0),  mk(0,0,P3,63,0,0),
    mk(0,1,P4,0,0,0),   mk(0,0,P4,1,0,0),   mk(0,0,P4,2,1,4),
    mk(0,0,P5,5,0,0),   mk(0,0,P5,6,0,0),   mk(0,0,P5,7,0,0),
    mk(3,1,P6,5,0,0),   mk(3,1,P6,6,0,0),   mk(3,1,P6,7,0,0),
    mk(0,1,P7,3,0,0),   mk(0,0,P7,2,0,0),   mk(0,0,P7,1,0,0),   mk(0,0,P7,0,0,0),
    mk(0,0,P1,16,1,18), mk(0,0,P1,16,0,0)
  };
  // Requirement exercised by each row
  localparam string VTAG [NV] = '{
    "R11","R2","R2","R5","R5","R5",
    "R1","R1","R1","R1","R2","R2","R2",
    "R3","R3","R3","R3",
    "R4","R4","R4",
    "R6","R6","R6",
    "R7","R7","R7",
    "R3","R1","R3","R3",
    "R10","R10"
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_src = '0;
  logic              req_miss = 1'b0;
  logic              pf_ready = 1'b1;
  logic              pf_valid;
  logic [ADDR_W-1:0] pf_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  line_stream_pf #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_src(req_src), .req_miss(req_miss), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  task automatic step(input logic [1:0] s, input logic m, input logic [19:0] p, input int i, input logic [5:0] off);
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = s;
    req_miss  = m;
    req_addr  = {p, 6'(i), off};
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ev, input logic [19:0] p, input int ei);
    logic [ADDR_W-1:0] ea;
    ea = {p, 6'(ei), 6'b0};
    n_chk++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      n_bad++;
      $display("FAIL %s: actual valid=%b addr=%h expected valid=%b addr=%h",
               tag, pf_valid, pf_addr, ev, ea);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", 1'b0, 20'h0, 0);
    n_chk++;
    if (pf_addr !== '0) begin
      n_bad++;
      $display("FAIL R11 reset addr: actual=%h expected=0", pf_addr);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][35:34], VEC[v][33], VEC[v][32:13], int'(VEC[v][12:7]), 6'h00);
      check(VTAG[v], VEC[v][6], VEC[v][32:13], int'(VEC[v][5:0]));
    end
    idle();
    check("R9 drain", 1'b0, P1, 0);

    // Back-pressure: the slot holds, a blocked candidate is dropped
    @(negedge clk); pf_ready = 1'b0;
    step(0, 1, P8, 20, 6'h3F); check("R9", 1'b0, P8, 0);
    step(0, 0, P8, 21, 6'h15); check("R1", 1'b0, P8, 0);
    step(0, 0, P8, 22, 6'h3F); check("R2 offset ignored", 1'b1, P8, 24);
    step(0, 0, P8, 23, 6'h00); check("R9 blocked", 1'b1, P8, 24);
    idle();                    check("R9 hold", 1'b1, P8, 24);
    @(negedge clk); pf_ready = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1;        check("R9 accept", 1'b0, P8, 0);
    step(0, 0, P8, 24, 6'h00); check("R9 after drop", 1'b1, P8, 26);

    // Replacement: P2 is the least recently touched stream
    step(0, 1, P9, 8, 6'h00);  check("R8", 1'b0, P9, 0);
    step(0, 1, P10, 8, 6'h00); check("R8", 1'b0, P10, 0);
    step(0, 1, P11, 8, 6'h00); check("R8", 1'b0, P11, 0);
    step(0, 0, P2, 41, 6'h00); check("R8 evicted", 1'b0, P2, 0);
    step(0, 0, P1, 17, 6'h00); check("R8 retained", 1'b1, P1, 19);

    // Reset clears the table
    @(negedge clk); req_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, P1, 18, 6'h00); check("R11 cleared", 1'b0, P1, 0);
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule